// File: doc/BRIEF.md
# Switched Output Channel Fault Supervisor

This block supervises one switched power output. A command input asks for the load to be energised. Comparator inputs report overcurrent, thermal warning, thermal trip, undervoltage, overvoltage and open load, plus one bit that tells a supply short from a ground short. From these inputs the block decides when the gate of the power switch may be driven. After reset the channel is held off. It starts only when no undervoltage and no thermal trip are present. A blanking window after every turn-on lets inrush current pass without being taken for a short.

A short that outlasts the blanking window is handled by one of two policies. The first latches the channel off until software clears it. The second retries after a wait that doubles on every attempt. Once a programmed number of retries has been used, the channel locks out. A thermal trip or an undervoltage switches the channel off, and it restarts under the same health gating as at power-up. Thermal warning, overvoltage and open load are flagged without switching the channel off. Every event records a cause code and an action code and bumps a saturating counter for its cause. Software reads all of this through a small address/data read port.

Top module: `outch_guard`

## Requirements
- R1: From reset `gate_en` is 0 and every read location returns 0. With `en_cmd` high, the gate rises one cycle after both `uv_in` and `tt_in` are low, and it stays low while either of them is high.
- R2: After each turn-on, `oc_in` is ignored for the first max(`cfg_blank`,1) cycles of gate-on time. If `oc_in` is held high from turn-on, `gate_en` stays high for exactly max(`cfg_blank`,1)+1 cycles. If it falls inside the window, the channel keeps running.
- R3: With `cfg_retry_on`=0, a short latches the gate off with action code 2 and channel state 4. A `clr` pulse while `oc_in` is high changes nothing. A `clr` pulse while `oc_in` is low clears `fault_flag` and releases the channel, which restarts if `en_cmd` is high.
- R4: With `cfg_retry_on`=1, the n-th consecutive short (n counted from 0) holds the gate off for max(`cfg_base`·2^n,1) cycles and then retries. The retry count (status bits 8:6) increments on each retry, and the action code is 3.
- R5: A short that occurs when the retry count equals `cfg_retry_lim` enters lockout (state 5, action 4). Toggling `en_cmd` does not release lockout. Only `clr` with `oc_in` low releases it, and that also zeroes the retry count.
- R6: Dropping `en_cmd` during a retry wait cancels the retry. The gate stays off and the channel returns to state 0.
- R7: The retry count returns to 0 once the channel has been in the running state (state 2) for `cfg_good` consecutive cycles without a fault.
- R8: A thermal warning drives `derate` high while the gate is on and sets the sticky warning bit (status bit 10), which `clr` clears. The gate stays on.
- R9: A thermal trip (cause 3) or undervoltage (cause 4) while the gate is on switches the gate off at the next edge with action code 1. The channel restarts one cycle after the condition clears.
- R10: Open load (cause 6, action 0) is counted once per assertion, and only in the running state with `en_cmd` high; during blanking it is ignored. It does not switch the channel off. A short is cause 2 when `sc_to_supply` is 1 and cause 1 otherwise.
- R11: A rising edge of `ov_in` records cause 5 with action 0 and counts one event, without changing `gate_en`.
- R12: Every event adds one to the counter of its cause, and each counter saturates at 2^`EVT_W`−1. When a switch-off event and a flag-only event fall in the same cycle, both counters advance and the last cause names the switch-off event.
- R13: Read address 0 returns status: cause in bits 2:0, action in 5:3, retry count in 8:6, fault in 9, warning in 10, undervoltage in 11, overvoltage in 12, and channel state in 15:13 (0 off, 1 blanking, 2 running, 3 retry wait, 4 latched, 5 lockout). Addresses 1 to 6 return the counter for that cause code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_cmd | input | 1 | Request to energise the load |
| clr | input | 1 | Clear pulse: releases latch/lockout, clears sticky flags |
| oc_in | input | 1 | Overcurrent comparator |
| sc_to_supply | input | 1 | Short class: 1 short to supply, 0 short to ground |
| tw_in | input | 1 | Thermal warning comparator |
| tt_in | input | 1 | Thermal trip comparator |
| uv_in | input | 1 | Undervoltage comparator |
| ov_in | input | 1 | Overvoltage comparator |
| ol_in | input | 1 | Open-load comparator |
| cfg_retry_on | input | 1 | 0 latch-off policy, 1 bounded auto-retry |
| cfg_blank | input | BLANK_W | Inrush blanking length in cycles |
| cfg_base | input | TICK_W | First retry wait in cycles |
| cfg_retry_lim | input | RETRY_W | Retries allowed before lockout |
| cfg_good | input | GOOD_W | Fault-free running cycles that reset the retry count |
| rd_addr | input | 3 | Read address |
| gate_en | output | 1 | Gate enable for the power switch |
| derate | output | 1 | Foldback request during thermal warning |
| fault_flag | output | 1 | Sticky fault indication |
| rd_data | output | DATA_W | Read data |

## Verification
A short, which switches the channel off, and an overvoltage rising edge, which is only flagged, can land on the same clock edge. The block then has to advance two counters at once and pick one last cause. The bench provokes this by raising `oc_in` and `ov_in` on the same falling edge while the channel is running past its blanking window. It then expects the gate to drop, the short and overvoltage counters each to advance by one, and the status cause field to name the short. Retry timing, blanking length and the short class are drawn from a fixed-seed random source, and the expected gate-on and gate-off lengths are computed from those draws.

// File: rtl/outch_pkg.sv
package outch_pkg;

   typedef enum logic [2:0] {
      CH_OFF   = 3'd0,
      CH_BLANK = 3'd1,
      CH_ON    = 3'd2,
      CH_WAIT  = 3'd3,
      CH_LATCH = 3'd4,
      CH_LOCK  = 3'd5
   } ch_state_e;

   localparam int NCAUSE = 6;

   localparam logic [2:0] CS_NONE = 3'd0;
   localparam logic [2:0] CS_STG  = 3'd1;
   localparam logic [2:0] CS_STS  = 3'd2;
   localparam logic [2:0] CS_OT   = 3'd3;
   localparam logic [2:0] CS_UV   = 3'd4;
   localparam logic [2:0] CS_OV   = 3'd5;
   localparam logic [2:0] CS_OL   = 3'd6;

   localparam logic [2:0] ACT_FLAG  = 3'd0;
   localparam logic [2:0] ACT_GATE  = 3'd1;
   localparam logic [2:0] ACT_LATCH = 3'd2;
   localparam logic [2:0] ACT_RETRY = 3'd3;
   localparam logic [2:0] ACT_LOCK  = 3'd4;

endpackage

// File: rtl/outch_satcnt.sv
module outch_satcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
   end

   // R12
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAXV) |=> (cnt == MAXV));

   // R12
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt != MAXV) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/outch_evbank.sv
module outch_evbank #(
   parameter int N = 6,
   parameter int W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   hit,
   output logic [N*W-1:0] cnt_flat
);
   generate
      if (N < 1 || W < 1) begin : g_bad
         $error("outch_evbank: N and W must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_cnt
         outch_satcnt #(.W(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (hit[i]),
            .cnt   (cnt_flat[i*W +: W])
         );
      end
   endgenerate
endmodule

// File: rtl/outch_backoff.sv
module outch_backoff #(
   parameter int TICK_W  = 10,
   parameter int RETRY_W = 3,
   parameter int WAIT_W  = 17,
   parameter bit EXP     = 1'b1
) (
   input  logic [TICK_W-1:0]  base,
   input  logic [RETRY_W-1:0] nret,
   output logic [WAIT_W-1:0]  wait_o
);
   generate
      if (WAIT_W < TICK_W + (1 << RETRY_W) - 1) begin : g_bad
         $error("outch_backoff: WAIT_W too narrow for the shifted base");
      end
      if (EXP) begin : g_dbl
         assign wait_o = WAIT_W'(base) << nret;
      end else begin : g_flat
         logic unused_n;
         assign unused_n = ^nret;
         assign wait_o   = WAIT_W'(base);
      end
   endgenerate
endmodule

// File: rtl/outch_dntimer.sv
module outch_dntimer #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign done = (cnt <= W'(1));
endmodule

// File: rtl/outch_guard.sv
module outch_guard
   import outch_pkg::*;
#(
   parameter int BLANK_W     = 8,
   parameter int TICK_W      = 10,
   parameter int RETRY_W     = 3,
   parameter int EVT_W       = 4,
   parameter int GOOD_W      = 12,
   parameter int DATA_W      = 16,
   parameter bit EXP_BACKOFF = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_cmd,
   input  logic               clr,
   input  logic               oc_in,
   input  logic               sc_to_supply,
   input  logic               tw_in,
   input  logic               tt_in,
   input  logic               uv_in,
   input  logic               ov_in,
   input  logic               ol_in,
   input  logic               cfg_retry_on,
   input  logic [BLANK_W-1:0] cfg_blank,
   input  logic [TICK_W-1:0]  cfg_base,
   input  logic [RETRY_W-1:0] cfg_retry_lim,
   input  logic [GOOD_W-1:0]  cfg_good,
   input  logic [2:0]         rd_addr,
   output logic               gate_en,
   output logic               derate,
   output logic               fault_flag,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int WAIT_W = TICK_W + (1 << RETRY_W) - 1;
   localparam int STAT_W = 13 + RETRY_W;

   generate
      if (STAT_W > DATA_W || EVT_W > DATA_W) begin : g_bad_data
         $error("outch_guard: DATA_W too narrow for status or counters");
      end
      if (BLANK_W > WAIT_W) begin : g_bad_blank
         $error("outch_guard: BLANK_W exceeds shared timer width");
      end
   endgenerate

   ch_state_e            st, st_n;
   logic [RETRY_W-1:0]   rcnt, rcnt_n;
   logic [GOOD_W-1:0]    good;
   logic [2:0]           cause_q, act_q;
   logic                 fault_q, warn_q, tw_q, uv_q, ov_q, olq_q;
   logic                 healthy, trip, clr_take, ol_now, ol_ev, ov_ev;
   logic [2:0]           t_cause, t_act;
   logic                 tmr_load, tmr_done;
   logic [WAIT_W-1:0]    tmr_val, bo_wait;
   logic [NCAUSE-1:0]    hit;
   logic [NCAUSE*EVT_W-1:0] cnt_flat;
   logic [STAT_W-1:0]    status;

   assign healthy  = !uv_in && !tt_in;
   assign clr_take = clr && !(((st == CH_LATCH) || (st == CH_LOCK)) && oc_in);
   assign ol_now   = (st == CH_ON) && en_cmd && ol_in;
   assign ol_ev    = ol_now && !olq_q;
   assign ov_ev    = ov_in && !ov_q;

   outch_backoff #(
      .TICK_W (TICK_W),
      .RETRY_W(RETRY_W),
      .WAIT_W (WAIT_W),
      .EXP    (EXP_BACKOFF)
   ) u_backoff (
      .base  (cfg_base),
      .nret  (rcnt),
      .wait_o(bo_wait)
   );

   outch_dntimer #(.W(WAIT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .done    (tmr_done)
   );

   // channel policy
   always_comb begin
      st_n     = st;
      rcnt_n   = rcnt;
      trip     = 1'b0;
      t_cause  = CS_NONE;
      t_act    = ACT_FLAG;
      tmr_load = 1'b0;
      tmr_val  = WAIT_W'(cfg_blank);
      unique case (st)
         CH_OFF: begin
            if (en_cmd && healthy) begin
               st_n     = CH_BLANK;
               tmr_load = 1'b1;
            end
         end
         CH_BLANK, CH_ON: begin
            if (!en_cmd) begin
               st_n = CH_OFF;
            end else if (uv_in) begin
               st_n = CH_OFF; trip = 1'b1; t_cause = CS_UV; t_act = ACT_GATE;
            end else if (tt_in) begin
               st_n = CH_OFF; trip = 1'b1; t_cause = CS_OT; t_act = ACT_GATE;
            end else if (st == CH_ON && oc_in) begin
               trip    = 1'b1;
               t_cause = sc_to_supply ? CS_STS : CS_STG;
               if (!cfg_retry_on) begin
                  st_n  = CH_LATCH;
                  t_act = ACT_LATCH;
               end else if (rcnt == cfg_retry_lim) begin
                  st_n  = CH_LOCK;
                  t_act = ACT_LOCK;
               end else begin
                  st_n     = CH_WAIT;
                  t_act    = ACT_RETRY;
                  rcnt_n   = rcnt + 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = bo_wait;
               end
            end else if (st == CH_BLANK && tmr_done) begin
               st_n = CH_ON;
            end else if (st == CH_ON && good == cfg_good) begin
               rcnt_n = '0;
            end
         end
         CH_WAIT: begin
            if (!en_cmd) begin
               st_n = CH_OFF;
            end else if (tmr_done) begin
               if (healthy) begin
                  st_n     = CH_BLANK;
                  tmr_load = 1'b1;
               end else begin
                  st_n = CH_OFF;
               end
            end
         end
         CH_LATCH, CH_LOCK: begin
            if (clr_take) begin
               st_n   = CH_OFF;
               rcnt_n = '0;
            end
         end
         default: st_n = CH_OFF;
      endcase
   end

   // events per cause, index = cause code - 1
   always_comb begin
      hit = '0;
      if (trip)  hit[int'(t_cause) - 1] = 1'b1;
      if (ol_ev) hit[int'(CS_OL) - 1]   = 1'b1;
      if (ov_ev) hit[int'(CS_OV) - 1]   = 1'b1;
   end

   outch_evbank #(.N(NCAUSE), .W(EVT_W)) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .cnt_flat(cnt_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= CH_OFF;
         rcnt    <= '0;
         good    <= '0;
         cause_q <= CS_NONE;
         act_q   <= ACT_FLAG;
         fault_q <= 1'b0;
         warn_q  <= 1'b0;
         tw_q    <= 1'b0;
         uv_q    <= 1'b0;
         ov_q    <= 1'b0;
         olq_q   <= 1'b0;
      end else begin
         st    <= st_n;
         rcnt  <= rcnt_n;
         tw_q  <= tw_in;
         uv_q  <= uv_in;
         ov_q  <= ov_in;
         olq_q <= ol_now;
         if (st != CH_ON)         good <= '0;
         else if (good != cfg_good) good <= good + 1'b1;
         if (trip) begin
            cause_q <= t_cause;
            act_q   <= t_act;
         end else if (ol_ev) begin
            cause_q <= CS_OL;
            act_q   <= ACT_FLAG;
         end else if (ov_ev) begin
            cause_q <= CS_OV;
            act_q   <= ACT_FLAG;
         end
         if (trip || ol_ev || ov_ev) fault_q <= 1'b1;
         else if (clr_take)          fault_q <= 1'b0;
         if (tw_in)                  warn_q  <= 1'b1;
         else if (clr_take)          warn_q  <= 1'b0;
      end
   end

   assign gate_en    = (st == CH_BLANK) || (st == CH_ON);
   assign derate     = tw_q && gate_en;
   assign fault_flag = fault_q;
   assign status     = {st, ov_q, uv_q, warn_q, fault_q, rcnt, act_q, cause_q};

   always_comb begin
      rd_data = '0;
      if (rd_addr == 3'd0) begin
         rd_data[STAT_W-1:0] = status;
      end else if (int'(rd_addr) <= NCAUSE) begin
         rd_data[EVT_W-1:0] = cnt_flat[(int'(rd_addr) - 1)*EVT_W +: EVT_W];
      end
   end

   // R1
   health_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> $past(en_cmd && !uv_in && !tt_in));

   // R2
   blank_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_BLANK && en_cmd && !uv_in && !tt_in) |=> gate_en);

   // R3
   clr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_LATCH && clr && oc_in) |=> (st == CH_LATCH));

   // R5
   lock_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_LOCK && !clr) |=> (st == CH_LOCK));

   // R6
   cancel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_WAIT && !en_cmd) |=> !gate_en);

   // R8
   warn_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_in && gate_en && en_cmd && !uv_in && !tt_in && !oc_in) |=> gate_en);

   // R9
   uv_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && uv_in) |=> !gate_en);
endmodule

// File: tb/outch_guard_tb.sv
module outch_guard_tb;
   localparam int EMAX = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_cmd = 0, clr = 0, oc_in = 0, sc_to_supply = 0;
   logic        tw_in = 0, tt_in = 0, uv_in = 0, ov_in = 0, ol_in = 0;
   logic        cfg_retry_on = 0;
   logic [7:0]  cfg_blank = 8'd4;
   logic [9:0]  cfg_base = 10'd4;
   logic [2:0]  cfg_retry_lim = 3'd2;
   logic [11:0] cfg_good = 12'd2000;
   logic [2:0]  rd_addr = 3'd0;
   logic        gate_en, derate, fault_flag;
   logic [15:0] rd_data;

   int total = 0;
   int bad = 0;
   int expc[1:6];
   bit finished = 0;

   always #10 clk = ~clk;

   outch_guard u_dut (
      .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .clr(clr), .oc_in(oc_in),
      .sc_to_supply(sc_to_supply), .tw_in(tw_in), .tt_in(tt_in), .uv_in(uv_in),
      .ov_in(ov_in), .ol_in(ol_in), .cfg_retry_on(cfg_retry_on),
      .cfg_blank(cfg_blank), .cfg_base(cfg_base), .cfg_retry_lim(cfg_retry_lim),
      .cfg_good(cfg_good), .rd_addr(rd_addr), .gate_en(gate_en),
      .derate(derate), .fault_flag(fault_flag), .rd_data(rd_data)
   );

   function automatic int on_len(int b);
      return ((b < 1) ? 1 : b) + 1;
   endfunction

   function automatic int off_len(int base, int n);
      int w = base << n;
      return (w < 1) ? 1 : w;
   endfunction

   function automatic int sat(int x);
      return (x >= EMAX) ? EMAX : x + 1;
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic chk_stat(string req, int cause, int act, int state);
      logic [15:0] d;
      rd(3'd0, d);
      chk({req, " cause"}, int'(d[2:0]), cause);
      chk({req, " action"}, int'(d[5:3]), act);
      chk({req, " state"}, int'(d[15:13]), state);
   endtask

   task automatic chk_cnt(string req, int c);
      logic [15:0] d;
      rd(3'(c), d);
      chk(req, int'(d), expc[c]);
   endtask

   task automatic run_len(logic lvl, int lim, output int n);
      n = 0;
      while (gate_en == lvl && n < lim) begin
         n++;
         cyc(1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int n, b, base, sc, c;
      void'($urandom(32'd9137));
      for (int i = 1; i <= 6; i++) expc[i] = 0;

      cyc(3);
      chk("R1 reset gate", int'(gate_en), 0);
      rst_n = 1'b1;
      cyc(1);
      rd(3'd0, d);
      chk("R13 reset status", int'(d), 0);
      for (int i = 1; i <= 6; i++) chk_cnt("R13 reset counter", i);

      // R1 health gating
      uv_in = 1; en_cmd = 1;
      cyc(5);
      chk("R1 held by undervoltage", int'(gate_en), 0);
      uv_in = 0;
      cyc(1);
      chk("R1 start after health", int'(gate_en), 1);
      en_cmd = 0; cyc(1);
      tt_in = 1; en_cmd = 1;
      cyc(4);
      chk("R1 held by thermal trip", int'(gate_en), 0);
      tt_in = 0;
      cyc(1);
      chk("R1 start after trip clears", int'(gate_en), 1);
      en_cmd = 0; cyc(2);

      // R2 blanking with latch policy, random windows and short class
      for (int k = 0; k < 5; k++) begin
         b  = (k == 0) ? 0 : 1 + int'($urandom % 12);
         sc = int'($urandom % 2);
         cfg_blank = 8'(b); sc_to_supply = sc[0];
         oc_in = 1; en_cmd = 1;
         cyc(1);
         run_len(1'b1, 100, n);
         chk("R2 gate-on length with held overcurrent", n, on_len(b));
         c = sc ? 2 : 1;
         expc[c] = sat(expc[c]);
         chk_stat("R3/R10 latched short", c, 2, 4);
         chk_cnt("R12 short counter", c);
         oc_in = 0; clr = 1; cyc(1); clr = 0;
         chk("R3 off right after release", int'(gate_en), 0);
         cyc(1);
         chk("R3 restart after clear", int'(gate_en), 1);
         chk("R3 fault cleared", int'(fault_flag), 0);
         en_cmd = 0; cyc(2);
      end

      // R2 inrush inside window tolerated
      cfg_blank = 8'd6; oc_in = 1; en_cmd = 1;
      cyc(6);
      oc_in = 0;
      cyc(20);
      chk("R2 inrush tolerated", int'(gate_en), 1);
      rd(3'd0, d);
      chk("R2 running state", int'(d[15:13]), 2);
      chk_cnt("R2 no short counted", 1);
      en_cmd = 0; cyc(2);

      // R3 clear while overcurrent persists
      cfg_blank = 8'd2; sc_to_supply = 0; oc_in = 1; en_cmd = 1;
      cyc(1);
      run_len(1'b1, 100, n);
      expc[1] = sat(expc[1]);
      clr = 1; cyc(1); clr = 0;
      cyc(5);
      chk("R3 clear ignored with overcurrent", int'(gate_en), 0);
      chk("R3 fault kept", int'(fault_flag), 1);
      chk_stat("R3 still latched", 1, 2, 4);
      oc_in = 0; clr = 1; cyc(1); clr = 0;
      cyc(1);
      chk("R3 release with overcurrent gone", int'(gate_en), 1);
      en_cmd = 0; cyc(2);

      // R4 / R5 retry with doubling wait and lockout
      cfg_retry_on = 1; cfg_retry_lim = 3'd2; cfg_blank = 8'd3;
      base = 2 + int'($urandom % 8);
      cfg_base = 10'(base);
      oc_in = 1; en_cmd = 1;
      cyc(1);
      run_len(1'b1, 100, n);
      chk("R2 retry on-time", n, on_len(3));
      run_len(1'b0, 500, n);
      chk("R4 first wait", n, off_len(base, 0));
      rd(3'd0, d);
      chk("R4 retry count one", int'(d[8:6]), 1);
      run_len(1'b1, 100, n);
      chk("R4 on-time after retry", n, on_len(3));
      run_len(1'b0, 500, n);
      chk("R4 doubled wait", n, off_len(base, 1));
      run_len(1'b1, 100, n);
      expc[1] = sat(sat(sat(expc[1])));
      cyc(50);
      chk("R5 lockout off", int'(gate_en), 0);
      chk_stat("R5 lockout", 1, 4, 5);
      rd(3'd0, d);
      chk("R5 retry count at limit", int'(d[8:6]), 2);
      chk_cnt("R12 retry shorts counted", 1);
      en_cmd = 0; cyc(2); en_cmd = 1; cyc(5);
      chk("R5 enable toggle no release", int'(gate_en), 0);
      oc_in = 0; clr = 1; cyc(1); clr = 0;
      cyc(1);
      chk("R5 clear releases", int'(gate_en), 1);
      rd(3'd0, d);
      chk("R5 retry count zeroed", int'(d[8:6]), 0);
      en_cmd = 0; cyc(2);

      // R6 cancel, R7 good run
      cfg_retry_lim = 3'd3; cfg_base = 10'd20; cfg_good = 12'd30;
      oc_in = 1; en_cmd = 1;
      cyc(1);
      run_len(1'b1, 100, n);
      expc[1] = sat(expc[1]);
      cyc(2);
      en_cmd = 0;
      cyc(60);
      chk("R6 retry cancelled", int'(gate_en), 0);
      rd(3'd0, d);
      chk("R6 back to off", int'(d[15:13]), 0);
      oc_in = 0; en_cmd = 1;
      cyc(1);
      chk("R6 restart on new enable", int'(gate_en), 1);
      cyc(3);
      rd(3'd0, d);
      chk("R7 count kept before good run", int'(d[8:6]), 1);
      cyc(40);
      rd(3'd0, d);
      chk("R7 count cleared after good run", int'(d[8:6]), 0);
      cfg_retry_on = 0;

      // R8 thermal warning
      tw_in = 1;
      cyc(1);
      chk("R8 derate on", int'(derate), 1);
      rd(3'd0, d);
      chk("R8 warning bit", int'(d[10]), 1);
      cyc(5);
      chk("R8 gate kept", int'(gate_en), 1);
      tw_in = 0;
      cyc(1);
      chk("R8 derate off", int'(derate), 0);
      rd(3'd0, d);
      chk("R8 warning sticky", int'(d[10]), 1);

      // R9 thermal trip and undervoltage
      tt_in = 1;
      cyc(1);
      chk("R9 trip cuts gate", int'(gate_en), 0);
      expc[3] = sat(expc[3]);
      chk_stat("R9 trip", 3, 1, 0);
      chk_cnt("R9 trip counter", 3);
      cyc(3);
      tt_in = 0;
      cyc(1);
      chk("R9 restart after trip", int'(gate_en), 1);
      cyc(10);
      uv_in = 1;
      cyc(1);
      chk("R9 undervoltage cuts gate", int'(gate_en), 0);
      expc[4] = sat(expc[4]);
      chk_stat("R9 undervoltage", 4, 1, 0);
      chk_cnt("R9 undervoltage counter", 4);
      uv_in = 0;
      cyc(1);
      chk("R9 restart after undervoltage", int'(gate_en), 1);

      // R10 open load
      en_cmd = 0; cyc(2);
      cfg_blank = 8'd10; ol_in = 1; en_cmd = 1;
      cyc(4);
      chk_cnt("R10 open load ignored in blanking", 6);
      cyc(12);
      expc[6] = sat(expc[6]);
      chk_cnt("R10 open load counted", 6);
      chk_stat("R10 open load", 6, 0, 2);
      cyc(5);
      chk_cnt("R10 counted once", 6);
      chk("R10 gate kept", int'(gate_en), 1);
      ol_in = 0; cyc(1);

      // R11 overvoltage
      ov_in = 1;
      cyc(1);
      expc[5] = sat(expc[5]);
      chk_cnt("R11 overvoltage counted", 5);
      chk_stat("R11 overvoltage", 5, 0, 2);
      cyc(3);
      chk_cnt("R11 counted once", 5);
      chk("R11 gate kept", int'(gate_en), 1);
      ov_in = 0; cyc(1);

      // R12 short and overvoltage in one cycle
      sc_to_supply = 0;
      ov_in = 1; oc_in = 1;
      cyc(1);
      expc[5] = sat(expc[5]);
      expc[1] = sat(expc[1]);
      chk("R12 gate off on joint event", int'(gate_en), 0);
      chk_cnt("R12 joint overvoltage counter", 5);
      chk_cnt("R12 joint short counter", 1);
      chk_stat("R12 switch-off cause wins", 1, 2, 4);
      ov_in = 0; oc_in = 0; clr = 1; cyc(1); clr = 0;
      en_cmd = 0; cyc(3);

      // R12 saturation from random overvoltage pulses
      for (int i = 0; i < 20; i++) begin
         ov_in = 1;
         cyc(1 + int'($urandom % 3));
         ov_in = 0;
         cyc(1 + int'($urandom % 3));
         expc[5] = sat(expc[5]);
      end
      chk("R12 saturation model", expc[5], EMAX);
      chk_cnt("R12 counter saturated", 5);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule